// File: doc/BRIEF.md
# Width-Expanded Dual-Clock FIFO with Merged Status Flags

This block builds one wide FIFO out of several identical narrow FIFO lanes placed side by side. All lanes share the write clock, the read clock, the reset, the write request and the read request. Each lane stores its own slice of every word, and each lane synchronizes its pointers across the two clock domains on its own. Because of this, one lane can report "data available" or "room available" one cycle before or after its neighbours.

To hide that skew, the block merges the lane flags into one read-side flag and one write-side flag. The gate used for the merge depends on the mode. The block's write and read strobes are qualified by the merged flags, so every lane always performs the same operation on the same cycle. A word is therefore never split across two positions.

Two read behaviours are offered. In standard mode a read returns the word on the next read-clock edge. In fall-through mode the oldest word is already presented on the output, and a read discards it. The mode is taken from a pin while reset is held.

Top module: `wide_fifo_stack`

## Requirements
- R1: While reset is held and right after it is released, `canRead` is 0, `canWrite` is 1 and `dout` is all zeros.
- R2: In standard mode (`fwftSel`=0 during reset), with no reads, exactly 2^ADDR_W writes are accepted before `canWrite` stays low.
- R3: In fall-through mode (`fwftSel`=1 during reset), with no reads, exactly 2^ADDR_W+1 writes are accepted, because the presented word leaves lane storage.
- R4: A write is taken only on a `wclk` edge where `wen` and `canWrite` are both 1. A request while `canWrite` is 0 adds no word, so after draining, `canRead` stays 0.
- R5: A read is taken only on an `rclk` edge where `ren` and `canRead` are both 1. A request while `canRead` is 0 leaves `dout` unchanged.
- R6: In standard mode, `dout` shows the popped word after the read edge and holds it until the next accepted read.
- R7: In fall-through mode, when `canRead` is 1, `dout` already shows the oldest word without any read. It holds until a read is accepted.
- R8: In standard mode, `canRead` is the AND of the lanes' active-low empty flags. In fall-through mode, it is the inverse of the OR of the lanes' active-low output-ready flags. In both cases it is 1 only when every lane can deliver.
- R9: In standard mode, `canWrite` is the AND of the lanes' active-low full flags. In fall-through mode, it is the inverse of the OR of the lanes' active-low input-ready flags. `canWrite` falls only after an accepted write.
- R10: When one lane is given an extra synchronizer stage (one cycle of flag skew), every word comes out whole. Lane k's slice equals the value written to slice k, and words come out in order with none lost or repeated.
- R11: The mode is sampled on `rclk` only while `rstN` is low. Changing `fwftSel` after reset has no effect on read behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock shared by all lanes |
| rclk | input | 1 | Read clock shared by all lanes |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| fwftSel | input | 1 | Mode pin, 1 = fall-through; sampled while reset is low |
| wen | input | 1 | Write request |
| din | input | LANES*LANE_W | Write word; lane k takes bits [k*LANE_W +: LANE_W] |
| canWrite | output | 1 | Merged write-side flag: every lane has room |
| ren | input | 1 | Read request |
| dout | output | LANES*LANE_W | Read word, assembled from the lane slices |
| canRead | output | 1 | Merged read-side flag: every lane can deliver |

## Verification
The assertions check the following on every cycle:
- each merged flag drops only after an accepted operation in its own domain;
- the output word holds whenever no read is taken, in both modes;
- the latched mode stays constant once reset is released.

Only the bench scenarios can show that the merged flags actually hide the injected one-cycle skew. They do this by checking that every slice of every word lines up with what was written, in order. The same applies to the exact capacity in each mode and to the proof that refused requests leave no trace.

// File: rtl/wfifo_pkg.sv
`timescale 1ns/1ps
package wfifo_pkg;
  // Strobes from control to the lane datapath
  typedef struct packed {
    logic wrStrobe;  // write all lanes this wclk edge
    logic rdStrobe;  // read all lanes this rclk edge
    logic fwft;      // latched mode
  } strobe_t;
endpackage

// File: rtl/wfifo_sync.sv
`timescale 1ns/1ps
module wfifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/wfifo_lane.sv
`timescale 1ns/1ps
module wfifo_lane #(
  parameter int DATA_W  = 18,
  parameter int ADDR_W  = 4,
  parameter int WR_SYNC = 2,
  parameter int RD_SYNC = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic              fwft,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              emptyN,   // standard: low when no word stored
  output logic              fullN,    // standard: low when storage full
  output logic              outRdyN,  // fall-through: low when a word is presented
  output logic              inRdyN    // fall-through: low when room exists
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wrBin, wrGray, rdBin, rdGray;
  logic [PW-1:0] wrGraySync, rdGraySync;
  logic          memEmpty, memFull, popMem, outValid;

  // write domain
  always_ff @(posedge wclk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrStrobe) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= toGray(wrBin + 1'b1);
    end
  end

  always_ff @(posedge wclk) begin
    if (wrStrobe) mem[wrBin[ADDR_W-1:0]] <= din;
  end

  wfifo_sync #(.W(PW), .STAGES(RD_SYNC)) rdPtrSync_i (
    .clk(wclk), .rstN(rstN), .d(rdGray), .q(rdGraySync)
  );

  assign memFull = (wrGray == {~rdGraySync[PW-1:PW-2], rdGraySync[PW-3:0]});

  // read domain
  wfifo_sync #(.W(PW), .STAGES(WR_SYNC)) wrPtrSync_i (
    .clk(rclk), .rstN(rstN), .d(wrGray), .q(wrGraySync)
  );

  assign memEmpty = (rdGray == wrGraySync);
  assign popMem   = fwft ? (!memEmpty && (!outValid || rdStrobe)) : rdStrobe;

  always_ff @(posedge rclk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      dout     <= '0;
      outValid <= 1'b0;
    end else begin
      if (popMem) begin
        dout   <= mem[rdBin[ADDR_W-1:0]];
        rdBin  <= rdBin + 1'b1;
        rdGray <= toGray(rdBin + 1'b1);
      end
      if (fwft) begin
        if (popMem)        outValid <= 1'b1;
        else if (rdStrobe) outValid <= 1'b0;
      end
    end
  end

  assign emptyN  = !memEmpty;
  assign fullN   = !memFull;
  assign outRdyN = !outValid;
  assign inRdyN  = memFull;
endmodule

// File: rtl/wfifo_lanes.sv
`timescale 1ns/1ps
module wfifo_lanes
  import wfifo_pkg::*;
#(
  parameter int LANE_W      = 18,
  parameter int LANES       = 2,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SKEW_LANE   = LANES
) (
  input  logic                    wclk,
  input  logic                    rclk,
  input  logic                    rstN,
  input  strobe_t                 strobes,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic [LANES-1:0]        laneEmptyN,
  output logic [LANES-1:0]        laneFullN,
  output logic [LANES-1:0]        laneOutRdyN,
  output logic [LANES-1:0]        laneInRdyN
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int EXTRA = (i == SKEW_LANE) ? 1 : 0;
    wfifo_lane #(
      .DATA_W (LANE_W),
      .ADDR_W (ADDR_W),
      .WR_SYNC(SYNC_STAGES + EXTRA),
      .RD_SYNC(SYNC_STAGES + EXTRA)
    ) lane_i (
      .wclk    (wclk),
      .rclk    (rclk),
      .rstN    (rstN),
      .wrStrobe(strobes.wrStrobe),
      .rdStrobe(strobes.rdStrobe),
      .fwft    (strobes.fwft),
      .din     (din[i*LANE_W +: LANE_W]),
      .dout    (dout[i*LANE_W +: LANE_W]),
      .emptyN  (laneEmptyN[i]),
      .fullN   (laneFullN[i]),
      .outRdyN (laneOutRdyN[i]),
      .inRdyN  (laneInRdyN[i])
    );
  end
endmodule

// File: rtl/wfifo_ctrl.sv
`timescale 1ns/1ps
module wfifo_ctrl
  import wfifo_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             rclk,
  input  logic             rstN,
  input  logic             fwftSel,
  input  logic             wen,
  input  logic             ren,
  input  logic [LANES-1:0] laneEmptyN,
  input  logic [LANES-1:0] laneFullN,
  input  logic [LANES-1:0] laneOutRdyN,
  input  logic [LANES-1:0] laneInRdyN,
  output strobe_t          strobes,
  output logic             canRead,
  output logic             canWrite,
  output logic             fwftMode
);
  logic stdRead, stdWrite, ffRdyN, ffInN;

  // mode is captured only while reset is held
  always_ff @(posedge rclk) begin
    if (!rstN) fwftMode <= fwftSel;
  end

  // standard: AND of active-low empty/full; fall-through: OR of active-low ready
  assign stdRead  = &laneEmptyN;
  assign stdWrite = &laneFullN;
  assign ffRdyN   = |laneOutRdyN;
  assign ffInN    = |laneInRdyN;

  assign canRead  = rstN && (fwftMode ? !ffRdyN : stdRead);
  assign canWrite = fwftMode ? !ffInN : stdWrite;

  assign strobes.wrStrobe = wen && canWrite;
  assign strobes.rdStrobe = ren && canRead;
  assign strobes.fwft     = fwftMode;
endmodule

// File: rtl/wide_fifo_stack.sv
`timescale 1ns/1ps
module wide_fifo_stack
  import wfifo_pkg::*;
#(
  parameter int LANE_W      = 18,
  parameter int LANES       = 2,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SKEW_LANE   = LANES
) (
  input  logic                    wclk,
  input  logic                    rclk,
  input  logic                    rstN,
  input  logic                    fwftSel,
  input  logic                    wen,
  input  logic [LANES*LANE_W-1:0] din,
  output logic                    canWrite,
  input  logic                    ren,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    canRead
);
  strobe_t          strobes;
  logic [LANES-1:0] laneEmptyN, laneFullN, laneOutRdyN, laneInRdyN;
  logic             fwftMode;

  wfifo_ctrl #(.LANES(LANES)) ctrl_i (
    .rclk(rclk), .rstN(rstN), .fwftSel(fwftSel), .wen(wen), .ren(ren),
    .laneEmptyN(laneEmptyN), .laneFullN(laneFullN),
    .laneOutRdyN(laneOutRdyN), .laneInRdyN(laneInRdyN),
    .strobes(strobes), .canRead(canRead), .canWrite(canWrite),
    .fwftMode(fwftMode)
  );

  wfifo_lanes #(
    .LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W),
    .SYNC_STAGES(SYNC_STAGES), .SKEW_LANE(SKEW_LANE)
  ) lanes_i (
    .wclk(wclk), .rclk(rclk), .rstN(rstN), .strobes(strobes),
    .din(din), .dout(dout),
    .laneEmptyN(laneEmptyN), .laneFullN(laneFullN),
    .laneOutRdyN(laneOutRdyN), .laneInRdyN(laneInRdyN)
  );
endmodule

// File: rtl/wide_fifo_stack_chk.sv
`timescale 1ns/1ps
module wide_fifo_stack_chk #(
  parameter int W = 36
) (
  input logic         wclk,
  input logic         rclk,
  input logic         rstN,
  input logic         wen,
  input logic         ren,
  input logic         canRead,
  input logic         canWrite,
  input logic [W-1:0] dout,
  input logic         fwftMode
);
  // R8
  read_flag_drop_chk: assert property (@(posedge rclk) disable iff (!rstN)
    $fell(canRead) |-> $past(ren));

  // R9
  write_flag_drop_chk: assert property (@(posedge wclk) disable iff (!rstN)
    $fell(canWrite) |-> $past(wen));

  // R6
  std_hold_chk: assert property (@(posedge rclk) disable iff (!rstN)
    (!fwftMode && !(ren && canRead)) |=> $stable(dout));

  // R7
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rstN)
    (fwftMode && canRead && !ren) |=> (canRead && $stable(dout)));

  // R11
  mode_frozen_chk: assert property (@(posedge rclk) disable iff (!rstN)
    $past(rstN) |-> $stable(fwftMode));
endmodule

bind wide_fifo_stack wide_fifo_stack_chk #(.W(LANES*LANE_W)) chk_i (
  .wclk(wclk), .rclk(rclk), .rstN(rstN), .wen(wen), .ren(ren),
  .canRead(canRead), .canWrite(canWrite), .dout(dout), .fwftMode(fwftMode)
);

// File: tb/wide_fifo_stack_tb_top.sv
`timescale 1ns/1ps
module wide_fifo_stack_tb_top;
  localparam int LANE_W = 18;
  localparam int LANES  = 2;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int W      = LANE_W * LANES;

  logic wclk = 0, rclk = 0, rstN = 0, fwftSel = 0, wen = 0, ren = 0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic canWrite, canRead;

  int errors = 0, checks = 0;
  int rdMode = 0;          // 0 idle, 1 always, 2 random
  bit benchFwft = 0;
  bit pendStd = 0;
  logic [W-1:0] pendWord;
  logic [W-1:0] expQ[$];
  int seq = 0;
  int popCount = 0;
  bit done = 0;

  initial forever #2 wclk = ~wclk;
  initial begin #1; forever #2 rclk = ~rclk; end

  wide_fifo_stack #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W),
                    .SYNC_STAGES(2), .SKEW_LANE(1)) dut_i (
    .wclk(wclk), .rclk(rclk), .rstN(rstN), .fwftSel(fwftSel),
    .wen(wen), .din(din), .canWrite(canWrite),
    .ren(ren), .dout(dout), .canRead(canRead)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mkWord(input int n);
    logic [W-1:0] w;
    for (int k = 0; k < LANES; k++)
      w[k*LANE_W +: LANE_W] = LANE_W'((k << 16) | (n & 16'hffff));
    return w;
  endfunction

  // monitor: drives ren, pops expected words, compares output
  initial forever begin
    @(negedge rclk);
    if (pendStd) begin
      // R6 R10: standard word appears after the read edge
      check(dout === pendWord, "R10", 64'(dout), 64'(pendWord));
      pendStd = 0;
    end
    case (rdMode)
      1:       ren = 1;
      2:       ren = 1'($urandom_range(0, 1));
      default: ren = 0;
    endcase
    if (ren && canRead) begin
      if (expQ.size() == 0) begin
        check(0, "R4", 64'(dout), 64'hdead);
      end else begin
        logic [W-1:0] w;
        w = expQ.pop_front();
        popCount++;
        // R7 R10: fall-through word is visible before the read edge
        if (benchFwft) check(dout === w, "R10", 64'(dout), 64'(w));
        else begin pendStd = 1; pendWord = w; end
      end
    end
  end

  task automatic doReset(input bit mode);
    rdMode = 0; wen = 0;
    @(negedge wclk);
    rstN = 0; fwftSel = mode; benchFwft = mode;
    repeat (6) @(negedge wclk);
    rstN = 1;
    repeat (3) @(negedge wclk);
  endtask

  // hold wen for n cycles, returning how many writes were accepted
  task automatic pushCycles(input int n, input bit randomGap, output int accepted);
    accepted = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge wclk);
      wen = randomGap ? 1'($urandom_range(0, 1)) : 1'b1;
      din = mkWord(seq);
      if (wen && canWrite) begin
        expQ.push_back(din);
        seq++;
        accepted++;
      end
    end
    @(negedge wclk);
    wen = 0;
  endtask

  task automatic pushWords(input int n);
    int got = 0;
    while (got < n) begin
      @(negedge wclk);
      wen = 1'($urandom_range(0, 1));
      din = mkWord(seq);
      if (wen && canWrite) begin
        expQ.push_back(din);
        seq++;
        got++;
      end
    end
    @(negedge wclk);
    wen = 0;
  endtask

  task automatic drain();
    for (int c = 0; c < 400 && expQ.size() != 0; c++) @(negedge rclk);
    repeat (4) @(negedge rclk);
    check(expQ.size() == 0, "R10", 64'(expQ.size()), 64'd0);
  endtask

  initial begin
    int acc;
    logic [W-1:0] held;
    // ---------------- standard mode ----------------
    doReset(0);
    @(negedge rclk);
    check(canRead == 0, "R1", 64'(canRead), 64'd0);
    check(canWrite == 1, "R1", 64'(canWrite), 64'd1);
    check(dout == '0, "R1", 64'(dout), 64'd0);
    fwftSel = 1;  // R11: must be ignored after reset
    pushCycles(40, 0, acc);
    check(acc == DEPTH, "R2 R9", 64'(acc), 64'(DEPTH));
    repeat (8) @(negedge rclk);
    check(canRead == 1, "R8", 64'(canRead), 64'd1);
    check(dout == '0, "R11", 64'(dout), 64'd0);
    rdMode = 2;
    drain();
    // R4: requests refused while full left nothing behind
    repeat (20) @(negedge rclk);
    check(canRead == 0, "R4", 64'(canRead), 64'd0);
    check(popCount == DEPTH, "R4", 64'(popCount), 64'(DEPTH));
    // R5: reads while empty leave dout alone
    rdMode = 1;
    @(negedge rclk);
    held = dout;
    for (int c = 0; c < 8; c++) begin
      @(negedge rclk);
      check(dout === held && !canRead, "R5", 64'(dout), 64'(held));
    end
    // mixed traffic under skew
    rdMode = 2;
    pushWords(150);
    drain();

    // ---------------- fall-through mode ----------------
    doReset(1);
    @(negedge rclk);
    check(canRead == 0 && canWrite == 1, "R1", 64'({canRead, canWrite}), 64'h1);
    pushWords(1);
    repeat (10) @(negedge rclk);
    check(canRead == 1, "R7 R8", 64'(canRead), 64'd1);
    check(dout === expQ[0], "R7", 64'(dout), 64'(expQ[0]));
    pushCycles(40, 0, acc);
    check(acc + 1 == DEPTH + 1, "R3", 64'(acc + 1), 64'(DEPTH + 1));
    check(canWrite == 0, "R9", 64'(canWrite), 64'd0);
    rdMode = 2;
    drain();
    repeat (20) @(negedge rclk);
    check(canRead == 0, "R4", 64'(canRead), 64'd0);
    pushWords(150);
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge wclk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule